// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Controller

This block is the host-side controller for a serial converter that freezes up to six differential channels with a single strobe and then streams the results back over a three-wire link. When a start request is accepted, the controller raises the conversion strobe. Half a serial-clock period later it begins toggling the serial clock and captures the converter's data line on every rising clock edge.

The incoming stream is split into fixed 16-clock slots, one slot per enabled channel. From each slot a 14-bit result is taken at a configurable bit position, and the remaining pad bits are discarded. Each result is placed in its own lane of a parallel output, and a per-channel valid flag is set for it. A channel-count input, sampled when the start is accepted, shortens the burst to 16 clocks per enabled channel. Once the final slot is captured, a one-cycle done pulse is raised. The controller then holds off the next strobe for a parameterised acquisition gap, measured from the last rising clock edge. The serial clock period is derived from the system clock by a half-period divider, and a minimum period is enforced at elaboration.

Top module: `simsamp_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, conv_o, sck_o, valid_o, done_o and busy_o are all 0.
- R2: conv_o rises only on the cycle after start_i is sampled high in the idle state. The first sck_o rising edge follows exactly SCK_HALF system cycles after conv_o rises.
- R3: During a burst, every sck_o high phase and every low phase between rising edges lasts exactly SCK_HALF cycles. conv_o stays high for exactly 2*SCK_HALF cycles and falls with the first sck_o falling edge. sck_o is low whenever the controller is idle.
- R4: A burst produces exactly 16*n rising edges on sck_o. Here n is nch_i when nch_i is between 1 and 6; the values 0 and 7 select 6.
- R5: The bit sampled at the k-th rising edge belongs to slot k/16, at position k%16. Within slot c, positions MSB_POS through MSB_POS+13 carry the result MSB first (MSB_POS defaults to 0), and the other positions are discarded. The result of slot c appears on data_o[14*c +: 14].
- R6: valid_o is cleared when a start is accepted, and bit c is set when slot c has been captured. After a burst, exactly the low n bits are set.
- R7: done_o is a single-cycle pulse, raised once per burst in the same cycle that the last channel's valid bit first appears.
- R8: busy_o stays high from the start until ACQ_CYC cycles after the last rising edge. A start_i seen while busy_o is high is ignored. The next conv_o rise comes at least ACQ_CYC+1 cycles after the last sck_o rising edge.
- R9: A change of nch_i after a start has been accepted has no effect on that burst's length or on its valid flags.
- R10: Elaboration rejects any parameter set whose serial-clock period, 2*SCK_HALF*SYS_CLK_PS, is shorter than 40 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion and readout |
| nch_i | input | 3 | Number of channels to read (0 or 7 selects 6) |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion strobe |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | 84 | Six 14-bit results, channel 0 in the low lane |
| valid_o | output | 6 | Per-channel result valid |
| done_o | output | 1 | One-cycle pulse after the last slot is captured |
| busy_o | output | 1 | Burst or acquisition gap in progress |

## Verification
A misaligned slot counter or shift position would scramble the data lanes in the very burst where it occurs. Bit slips and wrong lane assignment therefore show up at the first done pulse as a miscompare against the known per-channel codes. A wrong rising-edge total or a faulty channel-count decode shows up as a wrong clock count and a wrong valid mask at the end of that same burst. A gap counter or phase counter that is off by one moves conv_o or an sck_o edge by a whole system cycle. This is visible in the lead, width and gap measurements of the burst where it happens, or of the burst that follows.

// File: rtl/simsamp_pkg.sv
// Shared types for the simultaneous-sampling readout controller.
// Assumes: single clock domain, no other consumers.
package simsamp_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_RUN,
        S_GAP
    } seq_state_t;
endpackage

// File: rtl/simsamp_seq.sv
// Burst sequencer: raises the conversion strobe, divides the system clock
// into the serial clock, counts rising edges and enforces the acquisition gap.
// Assumes: ACQ_CYC >= SCK_HALF, SCK_HALF >= 1, sdo sampled on cap_o cycles.
module simsamp_seq
    import simsamp_pkg::*;
#(
    parameter int NUM_CH     = 6,
    parameter int SLOT_BITS  = 16,
    parameter int SCK_HALF   = 3,
    parameter int ACQ_CYC    = 24,
    parameter int SYS_CLK_PS = 8000,
    parameter int MIN_SCK_PS = 40000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [$clog2(NUM_CH+1)-1:0]       nch_i,
    output logic                              conv_o,
    output logic                              sck_o,
    output logic                              cap_o,
    output logic                              clear_o,
    output logic                              done_o,
    output logic                              busy_o
);
    localparam int CHW  = $clog2(NUM_CH + 1);
    localparam int RW   = $clog2(NUM_CH * SLOT_BITS + 1);
    localparam int CMAX = (ACQ_CYC > SCK_HALF) ? ACQ_CYC : SCK_HALF;
    localparam int CW   = $clog2(CMAX + 1);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic [RW-1:0]  rises;
    logic [RW-1:0]  tot;
    logic [RW-1:0]  tot_nx;
    logic [CHW-1:0] n_eff;
    logic           half_end;

    // Parameter sanity: minimum serial clock period and gap length.
    initial begin
        p_min_period_r10: assert (2 * SCK_HALF * SYS_CLK_PS >= MIN_SCK_PS)
            else $error("serial clock period below minimum");
        p_gap_len_r8: assert (ACQ_CYC >= SCK_HALF && SCK_HALF >= 1)
            else $error("acquisition gap shorter than half clock");
    end

    // Decode the requested channel count into the burst length.
    always_comb begin
        n_eff    = (nch_i == '0 || nch_i > CHW'(NUM_CH)) ? CHW'(NUM_CH) : nch_i;
        tot_nx   = RW'(n_eff) * RW'(SLOT_BITS);
        half_end = (cnt == CW'(SCK_HALF - 1));
    end

    // Main sequencer: strobe, clock toggling, edge counting, gap timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            conv_o <= 1'b0;
            sck_o  <= 1'b0;
            cnt    <= '0;
            rises  <= '0;
            tot    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_i) begin
                        state  <= S_LEAD;
                        conv_o <= 1'b1;
                        cnt    <= '0;
                        rises  <= '0;
                        tot    <= tot_nx;
                    end
                end
                S_LEAD: begin
                    if (half_end) begin
                        state <= S_RUN;
                        sck_o <= 1'b1;
                        cnt   <= '0;
                        rises <= RW'(1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_RUN: begin
                    if (half_end) begin
                        cnt   <= '0;
                        sck_o <= ~sck_o;
                        if (sck_o) begin
                            conv_o <= 1'b0;
                        end else begin
                            rises <= rises + 1'b1;
                            if (rises == tot - 1'b1) begin
                                state  <= S_GAP;
                                done_o <= 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (half_end) sck_o <= 1'b0;
                    if (cnt == CW'(ACQ_CYC - 1)) state <= S_IDLE;
                end
            endcase
        end
    end

    // Capture strobe on each cycle where the serial clock is about to rise.
    always_comb begin
        cap_o   = half_end && ((state == S_LEAD) || (state == S_RUN && !sck_o));
        clear_o = (state == S_IDLE) && start_i;
        busy_o  = (state != S_IDLE);
    end

    p_conv_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> ($past(start_i) && $past(state) == S_IDLE));
    p_lead_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAD) |-> (conv_o && !sck_o));
    p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sck_o);
    p_rises_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (rises <= tot));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_gap_no_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> !conv_o);
endmodule

// File: rtl/simsamp_deser.sv
// Slot deserialiser: tracks the bit position inside each 16-bit slot,
// keeps the result window and writes it into the lane of the current channel.
// Assumes: cap_i marks the cycle on which sdo_i holds the next stream bit.
module simsamp_deser #(
    parameter int NUM_CH    = 6,
    parameter int SLOT_BITS = 16,
    parameter int DATA_BITS = 14,
    parameter int MSB_POS   = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        cap_i,
    input  logic                        sdo_i,
    output logic [NUM_CH*DATA_BITS-1:0] data_o,
    output logic [NUM_CH-1:0]           valid_o
);
    localparam int BW  = $clog2(SLOT_BITS);
    localparam int CHW = $clog2(NUM_CH + 1);

    logic [BW-1:0]        bidx;
    logic [CHW-1:0]       ch;
    logic [DATA_BITS-1:0] dsh;
    logic [DATA_BITS-1:0] dsh_nx;
    logic                 in_win;
    logic                 slot_end;

    initial begin
        p_window_fits_r5: assert (MSB_POS + DATA_BITS <= SLOT_BITS)
            else $error("result window exceeds slot");
    end

    // Decide whether the current bit lies in the result window.
    always_comb begin
        in_win   = (bidx >= BW'(MSB_POS)) && (bidx <= BW'(MSB_POS + DATA_BITS - 1));
        dsh_nx   = in_win ? {dsh[DATA_BITS-2:0], sdo_i} : dsh;
        slot_end = cap_i && (bidx == BW'(SLOT_BITS - 1));
    end

    // Bit and channel position tracking plus window shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            bidx <= '0;
            ch   <= '0;
            dsh  <= '0;
        end else if (cap_i) begin
            dsh <= dsh_nx;
            if (slot_end) begin
                bidx <= '0;
                ch   <= ch + 1'b1;
            end else begin
                bidx <= bidx + 1'b1;
            end
        end
    end

    // One result lane and valid flag per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[g*DATA_BITS +: DATA_BITS] <= '0;
                valid_o[g]                       <= 1'b0;
            end else if (clear_i) begin
                valid_o[g] <= 1'b0;
            end else if (slot_end && ch == CHW'(g)) begin
                data_o[g*DATA_BITS +: DATA_BITS] <= dsh_nx;
                valid_o[g]                       <= 1'b1;
            end
        end
    end

    p_ch_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ch <= CHW'(NUM_CH));
    p_valid_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (valid_o == '0));
    p_valid_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((valid_o & $past(valid_o)) == $past(valid_o)));
endmodule

// File: rtl/simsamp_reader.sv
// Top of the readout controller: joins the burst sequencer and the slot
// deserialiser. Assumes sdo_i is already synchronous to clk.
module simsamp_reader #(
    parameter int NUM_CH     = 6,
    parameter int SLOT_BITS  = 16,
    parameter int DATA_BITS  = 14,
    parameter int MSB_POS    = 0,
    parameter int SCK_HALF   = 3,
    parameter int ACQ_CYC    = 24,
    parameter int SYS_CLK_PS = 8000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [$clog2(NUM_CH+1)-1:0]   nch_i,
    input  logic                          sdo_i,
    output logic                          conv_o,
    output logic                          sck_o,
    output logic [NUM_CH*DATA_BITS-1:0]   data_o,
    output logic [NUM_CH-1:0]             valid_o,
    output logic                          done_o,
    output logic                          busy_o
);
    logic cap;
    logic clear;

    simsamp_seq #(
        .NUM_CH(NUM_CH), .SLOT_BITS(SLOT_BITS), .SCK_HALF(SCK_HALF),
        .ACQ_CYC(ACQ_CYC), .SYS_CLK_PS(SYS_CLK_PS), .MIN_SCK_PS(40000)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .nch_i(nch_i),
        .conv_o(conv_o), .sck_o(sck_o), .cap_o(cap), .clear_o(clear),
        .done_o(done_o), .busy_o(busy_o)
    );

    simsamp_deser #(
        .NUM_CH(NUM_CH), .SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS),
        .MSB_POS(MSB_POS)
    ) u_deser (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .cap_i(cap), .sdo_i(sdo_i),
        .data_o(data_o), .valid_o(valid_o)
    );

    p_done_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (valid_o != '0));
endmodule

// File: tb/simsamp_reader_test.sv
// Self-checking bench: behavioural converter stub with known per-channel
// codes, edge and width monitor, directed and seeded random bursts.
module simsamp_reader_test;
    localparam int NCH  = 6;
    localparam int SLOT = 16;
    localparam int DB   = 14;
    localparam int MSB  = 0;
    localparam int H    = 3;
    localparam int ACQ  = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2:0]      nch = 3'd6;
    logic            sdo = 1'b1;
    logic            conv, sck, done, busy;
    logic [NCH*DB-1:0] data;
    logic [NCH-1:0]  valid;

    int nchecks = 0;
    int nfail   = 0;

    always #4 clk = ~clk;

    simsamp_reader #(
        .NUM_CH(NCH), .SLOT_BITS(SLOT), .DATA_BITS(DB), .MSB_POS(MSB),
        .SCK_HALF(H), .ACQ_CYC(ACQ), .SYS_CLK_PS(8000)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .nch_i(nch), .sdo_i(sdo),
        .conv_o(conv), .sck_o(sck), .data_o(data), .valid_o(valid),
        .done_o(done), .busy_o(busy)
    );

    // ---------------- converter stub ----------------
    logic [DB-1:0] code [NCH];
    int sidx = 0;

    function automatic logic stream_bit(input int k);
        int c = k / SLOT;
        int j = k % SLOT;
        if (c >= NCH) return 1'b1;
        if (j >= MSB && j < MSB + DB) return code[c][DB-1-(j-MSB)];
        return 1'b1;
    endfunction

    always @(posedge conv) begin
        sidx = 0;
        sdo  = stream_bit(0);
    end

    always @(posedge sck) begin
        #1;
        sidx = sidx + 1;
        sdo  = stream_bit(sidx);
    end

    // ---------------- edge monitor ----------------
    int ncyc = 0, conv_rise = 0, conv_width = 0, lead = -1, rises = 0;
    int last_rise = -1, last_fall = 0, bad_width = 0, dones = 0, conv_cnt = 0;
    int gap_min = 1 << 30;
    logic pconv = 1'b0, psck = 1'b0;

    always @(negedge clk) begin
        ncyc++;
        if (conv && !pconv) begin
            conv_rise = ncyc;
            rises = 0;
            conv_cnt++;
            if (last_rise >= 0 && (ncyc - last_rise) < gap_min) gap_min = ncyc - last_rise;
        end
        if (!conv && pconv) conv_width = ncyc - conv_rise;
        if (sck && !psck) begin
            if (rises == 0) lead = ncyc - conv_rise;
            else if (ncyc - last_fall != H) bad_width++;
            rises++;
            last_rise = ncyc;
        end
        if (!sck && psck && (ncyc - last_rise != H)) bad_width++;
        if (!sck && psck) last_fall = ncyc;
        if (done) dones++;
        pconv = conv;
        psck  = sck;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_n(input int r);
        return (r == 0 || r > NCH) ? NCH : r;
    endfunction

    // One burst: start, optional mid-burst disturbance, then check everything.
    task automatic run(input int nreq, input bit poke);
        int n = eff_n(nreq);
        int d0, c0, b0;
        logic [NCH-1:0] mask;
        while (busy) @(negedge clk);
        for (int c = 0; c < NCH; c++) code[c] = DB'($urandom);
        mask = NCH'((1 << n) - 1);
        d0 = dones; c0 = conv_cnt; b0 = bad_width;
        nch = 3'(nreq); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            nch = (n == 1) ? 3'd6 : 3'd1;          // R9 disturbance
            start = 1'b1;                           // R8 ignored start
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(valid == mask, "R6 valid mask", valid, mask);
        for (int c = 0; c < n; c++)
            check(data[c*DB +: DB] == code[c], "R5 lane data", data[c*DB +: DB], code[c]);
        check(busy == 1'b1, "R8 busy after done", busy, 1);
        @(negedge clk);
        check(done == 1'b0, "R7 done single", done, 0);
        check(rises == 16 * n, "R4 rising edges", rises, 16 * n);
        if (poke) check(rises == 16 * n && valid == mask, "R9 count held", rises, 16 * n);
        check(lead == H, "R2 strobe lead", lead, H);
        check(conv_width == 2 * H, "R3 strobe width", conv_width, 2 * H);
        check(bad_width == b0, "R3 sck phase width", bad_width - b0, 0);
        check(dones - d0 == 1, "R7 done count", dones - d0, 1);
        check(conv_cnt - c0 == 1, "R8 strobe count", conv_cnt - c0, 1);
        while (busy) @(negedge clk);
        check(sck == 1'b0 && conv == 1'b0, "R3 idle lines", {sck, conv}, 0);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check({conv, sck, valid, done, busy} == '0, "R1 in reset", {conv, sck, valid, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({conv, sck, valid, done, busy} == '0, "R1 after reset", {conv, sck, valid, done, busy}, 0);
        run(6, 1'b0);
        run(1, 1'b0);
        run(0, 1'b0);
        run(7, 1'b1);
        run(3, 1'b1);
        for (int i = 0; i < 10; i++) run($urandom_range(0, 7), 1'($urandom_range(0, 1)));
        check(gap_min >= ACQ + 1, "R8 acquisition gap", gap_min, ACQ + 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
        $finish;
    end
endmodule